// File: doc/BRIEF.md
# Video Mode Register and Pixel Mixer

This block sits on the Z80 I/O bus of an enhanced video subsystem. Six consecutive I/O ports, starting at a parameterised base (0xF8 by default), reach it. The ports hold the display mode, the graphics layer set-up and the CPU memory-mapping controls. Each field of these registers is brought out as its own signal, so the video timing, character and graphics logic can use the fields directly.

Three of the ports form a colour painter. Writing an 8-bit mask to the red, green or blue port raises a one-cycle write strobe toward the graphics RAM. The strobe carries the colour plane, the mask and the bank currently selected in the graphics layer register. A set mask bit marks a pixel in the current 8-pixel group that takes that colour component.

The block also mixes one pixel from character VRAM with one pixel from graphics RAM. Each source is gated by its own enable, and the two gated values are combined by OR or XOR. Reading the last port returns an externally supplied status byte.

Top module: `vmix_top`

## Requirements
- R1: While reset is held and after it is released, with no write made, the outputs are: scan mode 00, programmable characters off, colour off, 40 columns, machine model 100, graphics bank 0, both source enables off, blend OR, both CPU mappings off, no write strobe, and mixed pixel 0.
- R2: A write to port base+0 sets the mode fields from the data byte. Bits 7:6 give the scan mode, bit 5 the programmable-character enable, bit 4 the colour enable, bit 3 the 80-column select and bits 2:0 the machine model. The new values are visible after the clock edge that samples the write.
- R3: On a write to base+0, a model field of 111 leaves the model unchanged and a scan field of 11 leaves the scan mode unchanged. The other fields of the same write still take effect.
- R4: A write to port base+1 sets the graphics bank from bits 4:3, the character-VRAM enable from bit 2, the graphics-RAM enable from bit 1 and the blend operator from bit 0 (0 = OR, 1 = XOR). Bits 7:5 have no effect.
- R5: A write to port base+2, base+3 or base+4 raises the write strobe for exactly the next cycle. The strobe carries a plane code (0 for red at base+2, 1 for green at base+3, 2 for blue at base+4), the written mask and the bank held at that time.
- R6: A write to port base+5 sets the graphics-RAM CPU mapping from bit 0 and the character-ROM CPU mapping from bit 7. Bits 6:1 have no effect.
- R7: While a read strobe addresses base+5, the read data equals the status input in the same cycle. At any other address, or with no read strobe, the read data is zero.
- R8: One cycle after the pixel inputs are sampled, each mixed pixel bit equals (vram_en AND v) OR (gram_en AND g) when the blend bit is 0, and the same two terms combined by XOR when the blend bit is 1.
- R9: A source whose enable is off contributes zero, so with both enables off the mixed pixel is 0 whatever the inputs are.
- R10: A write to an address outside base+0 to base+5, or an addressed cycle with the write strobe low, changes no register and raises no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data |
| status_in | input | 8 | Video status byte returned on reads |
| vram_pix | input | PIX_W | Character VRAM pixel |
| gram_pix | input | PIX_W | Graphics RAM pixel |
| scan_mode | output | 2 | Scan mode select |
| pcg_en | output | 1 | Programmable characters enabled |
| colour_en | output | 1 | Colour display enabled |
| wide_cols | output | 1 | 80-column display |
| model | output | 3 | Machine model code |
| gram_bank | output | 2 | Selected graphics RAM bank |
| vram_en | output | 1 | Character VRAM output enabled |
| gram_en | output | 1 | Graphics RAM output enabled |
| blend_xor | output | 1 | Blend operator: 1 = XOR, 0 = OR |
| map_gram | output | 1 | Graphics RAM mapped to CPU window |
| map_cgrom | output | 1 | Character ROM mapped to CPU |
| gw_stb | output | 1 | Graphics RAM mask write strobe |
| gw_plane | output | 2 | Colour plane of the strobe |
| gw_mask | output | 8 | 8-pixel mask of the strobe |
| gw_bank | output | 2 | Bank of the strobe |
| pix_out | output | PIX_W | Mixed pixel |

## Verification
A register field changes at the clock edge that samples its write, so it is visible from the following falling edge. The paint strobe is high for exactly the cycle after that edge. The mixed pixel reflects pixel inputs sampled one edge earlier. The status read path has no register and answers in the same cycle. The bench drives every stimulus on a falling edge and compares each registered result at the next falling edge, half a period after the edge that produced it. It checks the read path a short delay after driving it. It sweeps all 256 values of each register port and every enable, operator and pixel combination of the mixer.

// File: rtl/vmix_pkg.sv
package vmix_pkg;

  localparam int NUM_PORTS = 6;
  localparam int OFS_MODE  = 0;
  localparam int OFS_LAYER = 1;
  localparam int OFS_RED   = 2;
  localparam int OFS_GREEN = 3;
  localparam int OFS_BLUE  = 4;
  localparam int OFS_PAGE  = 5;
  localparam int NUM_PLANES = 3;

  typedef enum logic [1:0] {
    PL_RED   = 2'd0,
    PL_GREEN = 2'd1,
    PL_BLUE  = 2'd2
  } plane_e;

  typedef struct packed {
    logic [1:0] scan;
    logic       pcg;
    logic       colour;
    logic       wide;
    logic [2:0] model;
  } mode_t;

  typedef struct packed {
    logic [1:0] bank;
    logic       vram_en;
    logic       gram_en;
    logic       blend_xor;
  } layer_t;

  typedef struct packed {
    logic cgrom;
    logic gram;
  } page_t;

  localparam logic [1:0] SCAN_RESERVED  = 2'b11;
  localparam logic [2:0] MODEL_RESERVED = 3'b111;
  localparam mode_t MODE_RESET = '{scan: 2'b00, pcg: 1'b0, colour: 1'b0,
                                   wide: 1'b0, model: 3'b100};

endpackage

// File: rtl/vmix_decode.sv
module vmix_decode
  import vmix_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = 8'hF8
) (
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  output logic [NUM_PORTS-1:0] wr_hit,
  output logic                 rd_status
);

  logic [NUM_PORTS-1:0] sel;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    assign sel[i]    = (io_addr == BASE_PORT + ADDR_W'(i));
    assign wr_hit[i] = io_wr & sel[i];
  end

  assign rd_status = io_rd & sel[OFS_PAGE];

endmodule

// File: rtl/vmix_regs.sv
module vmix_regs
  import vmix_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] wr_hit,
  input  logic [7:0]           io_wdata,
  output mode_t                mode_q,
  output layer_t               layer_q,
  output page_t                page_q
);

  mode_t  mode_d;
  layer_t layer_d;
  page_t  page_d;
  logic   mode_ce, layer_ce, page_ce;

  assign mode_ce  = wr_hit[OFS_MODE];
  assign layer_ce = wr_hit[OFS_LAYER];
  assign page_ce  = wr_hit[OFS_PAGE];

  always_comb begin
    mode_d        = mode_q;
    mode_d.pcg    = io_wdata[5];
    mode_d.colour = io_wdata[4];
    mode_d.wide   = io_wdata[3];
    if (io_wdata[7:6] != SCAN_RESERVED) mode_d.scan  = io_wdata[7:6];
    if (io_wdata[2:0] != MODEL_RESERVED) mode_d.model = io_wdata[2:0];
  end

  always_comb begin
    layer_d = layer_t'(io_wdata[4:0]);
  end

  always_comb begin
    page_d.cgrom = io_wdata[7];
    page_d.gram  = io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RESET;
      layer_q <= '0;
      page_q  <= '0;
    end else begin
      if (mode_ce)  mode_q  <= mode_d;
      if (layer_ce) layer_q <= layer_d;
      if (page_ce)  page_q  <= page_d;
    end
  end

  // R3: the reserved model code never becomes the active model
  p_model_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.model != MODEL_RESERVED);

  // R3: the reserved scan code never becomes the active scan mode
  p_scan_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.scan != SCAN_RESERVED);

  // R10: the mode register only moves on its own write
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit[OFS_MODE]) |-> $stable(mode_q));

  // R10: the layer register only moves on its own write
  p_layer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit[OFS_LAYER]) |-> $stable(layer_q));

endmodule

// File: rtl/vmix_cwriter.sv
module vmix_cwriter
  import vmix_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] wr_hit,
  input  logic [7:0]           io_wdata,
  input  logic [1:0]           bank,
  output logic                 stb_q,
  output plane_e               plane_q,
  output logic [7:0]           mask_q,
  output logic [1:0]           bank_q
);

  logic   stb_d;
  plane_e plane_d;

  always_comb begin
    stb_d   = 1'b0;
    plane_d = PL_RED;
    for (int i = 0; i < NUM_PLANES; i++) begin
      if (wr_hit[OFS_RED+i]) begin
        stb_d   = 1'b1;
        plane_d = plane_e'(2'(i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      plane_q <= PL_RED;
      mask_q  <= '0;
      bank_q  <= '0;
    end else begin
      stb_q <= stb_d;
      if (stb_d) begin
        plane_q <= plane_d;
        mask_q  <= io_wdata;
        bank_q  <= bank;
      end
    end
  end

  // R5: a strobe is always caused by a colour-port write one cycle earlier
  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(|wr_hit[OFS_BLUE:OFS_RED]));

  // R5: the plane code stays within the three colour planes
  p_plane_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> plane_q != 2'd3);

endmodule

// File: rtl/vmix_mixer.sv
module vmix_mixer #(
  parameter int PIX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vram_en,
  input  logic             gram_en,
  input  logic             blend_xor,
  input  logic [PIX_W-1:0] vram_pix,
  input  logic [PIX_W-1:0] gram_pix,
  output logic [PIX_W-1:0] pix_q
);

  logic [PIX_W-1:0] pix_d;

  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    logic v_g, g_g;
    assign v_g      = vram_en & vram_pix[i];
    assign g_g      = gram_en & gram_pix[i];
    assign pix_d[i] = blend_xor ? (v_g ^ g_g) : (v_g | g_g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  // R9: both sources disabled gives a dark pixel
  p_dark_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vram_en) && !$past(gram_en)) |-> pix_q == '0);

  // R8: with only the character source enabled the output follows it
  p_vram_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vram_en) && !$past(gram_en)) |-> pix_q == $past(vram_pix));

  // R8: OR never yields fewer set bits than the graphics source alone
  p_or_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gram_en) && !$past(blend_xor)) |-> (pix_q & $past(gram_pix)) == $past(gram_pix));

endmodule

// File: rtl/vmix_top.sv
module vmix_top
  import vmix_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = 8'hF8,
  parameter int                PIX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic [7:0]        status_in,
  input  logic [PIX_W-1:0]  vram_pix,
  input  logic [PIX_W-1:0]  gram_pix,
  output logic [1:0]        scan_mode,
  output logic              pcg_en,
  output logic              colour_en,
  output logic              wide_cols,
  output logic [2:0]        model,
  output logic [1:0]        gram_bank,
  output logic              vram_en,
  output logic              gram_en,
  output logic              blend_xor,
  output logic              map_gram,
  output logic              map_cgrom,
  output logic              gw_stb,
  output logic [1:0]        gw_plane,
  output logic [7:0]        gw_mask,
  output logic [1:0]        gw_bank,
  output logic [PIX_W-1:0]  pix_out
);

  logic                 rst_meta, rst_s;
  logic [NUM_PORTS-1:0] wr_hit;
  logic                 rd_status;
  mode_t                mode_q;
  layer_t               layer_q;
  page_t                page_q;
  plane_e               plane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  vmix_decode #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) i_decode (
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .wr_hit    (wr_hit),
    .rd_status (rd_status)
  );

  vmix_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_hit   (wr_hit),
    .io_wdata (io_wdata),
    .mode_q   (mode_q),
    .layer_q  (layer_q),
    .page_q   (page_q)
  );

  vmix_cwriter i_cwriter (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_hit   (wr_hit),
    .io_wdata (io_wdata),
    .bank     (layer_q.bank),
    .stb_q    (gw_stb),
    .plane_q  (plane_q),
    .mask_q   (gw_mask),
    .bank_q   (gw_bank)
  );

  vmix_mixer #(.PIX_W(PIX_W)) i_mixer (
    .clk       (clk),
    .rst_n     (rst_s),
    .vram_en   (layer_q.vram_en),
    .gram_en   (layer_q.gram_en),
    .blend_xor (layer_q.blend_xor),
    .vram_pix  (vram_pix),
    .gram_pix  (gram_pix),
    .pix_q     (pix_out)
  );

  assign io_rdata  = rd_status ? status_in : 8'h00;
  assign gw_plane  = plane_q;
  assign scan_mode = mode_q.scan;
  assign pcg_en    = mode_q.pcg;
  assign colour_en = mode_q.colour;
  assign wide_cols = mode_q.wide;
  assign model     = mode_q.model;
  assign gram_bank = layer_q.bank;
  assign vram_en   = layer_q.vram_en;
  assign gram_en   = layer_q.gram_en;
  assign blend_xor = layer_q.blend_xor;
  assign map_gram  = page_q.gram;
  assign map_cgrom = page_q.cgrom;

  // R5: the strobe carries the bank that is currently selected
  p_bank_match_r5: assert property (@(posedge clk) disable iff (!rst_s)
    gw_stb |-> gw_bank == gram_bank);

  // R6: the mapping controls only move on a page-port write
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(wr_hit[OFS_PAGE]) |-> $stable(page_q));

  // R7: read data is zero whenever no read is in progress
  p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !io_rd |-> io_rdata == 8'h00);

endmodule

// File: tb/test_vmix_top.sv
module test_vmix_top;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 2;
  localparam logic [7:0] BASE = 8'hF8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       io_addr, io_wdata, io_rdata, status_in;
  logic             io_wr, io_rd;
  logic [PIX_W-1:0] vram_pix, gram_pix, pix_out;
  logic [1:0]       scan_mode, gram_bank, gw_plane, gw_bank;
  logic             pcg_en, colour_en, wide_cols, vram_en, gram_en, blend_xor;
  logic             map_gram, map_cgrom, gw_stb;
  logic [2:0]       model;
  logic [7:0]       gw_mask;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0] exp_scan;
  logic [2:0] exp_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmix_top #(.ADDR_W(8), .BASE_PORT(BASE), .PIX_W(PIX_W)) i_vmix_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .status_in(status_in),
    .vram_pix(vram_pix), .gram_pix(gram_pix), .scan_mode(scan_mode),
    .pcg_en(pcg_en), .colour_en(colour_en), .wide_cols(wide_cols),
    .model(model), .gram_bank(gram_bank), .vram_en(vram_en), .gram_en(gram_en),
    .blend_xor(blend_xor), .map_gram(map_gram), .map_cgrom(map_cgrom),
    .gw_stb(gw_stb), .gw_plane(gw_plane), .gw_mask(gw_mask),
    .gw_bank(gw_bank), .pix_out(pix_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = en;
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  function automatic logic [31:0] mode_now();
    return {23'd0, scan_mode, pcg_en, colour_en, wide_cols, model};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = 8'h00; io_wdata = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
    status_in = 8'h00; vram_pix = '0; gram_pix = '0;
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1 held mode", mode_now(), 32'h04);
    chk("R1 held pix", 32'(pix_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode", mode_now(), 32'h04);
    chk("R1 layer", {27'd0, gram_bank, vram_en, gram_en, blend_xor}, 0);
    chk("R1 page", {30'd0, map_cgrom, map_gram}, 0);
    chk("R1 stb", 32'(gw_stb), 0);
    chk("R1 pix", 32'(pix_out), 0);
    exp_scan  = 2'b00;
    exp_model = 3'b100;

    // R10: writes outside the window or without the strobe do nothing
    wr(BASE - 8'd1, 8'hFF, 1'b1);
    chk("R10 below", mode_now(), 32'h04);
    chk("R10 below stb", 32'(gw_stb), 0);
    wr(BASE + 8'd6, 8'hFF, 1'b1);
    chk("R10 above page", {30'd0, map_cgrom, map_gram}, 0);
    wr(BASE, 8'hFB, 1'b0);
    chk("R10 no strobe", mode_now(), 32'h04);
    wr(BASE + 8'd2, 8'hAA, 1'b0);
    chk("R10 no strobe paint", 32'(gw_stb), 0);

    // R2 R3: sweep every value of the mode port
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      wr(BASE, d, 1'b1);
      if (d[7:6] != 2'b11) exp_scan = d[7:6];
      if (d[2:0] != 3'b111) exp_model = d[2:0];
      chk((d[7:6] == 2'b11 || d[2:0] == 3'b111) ? "R3 reserved code" : "R2 mode fields",
          mode_now(), {23'd0, exp_scan, d[5], d[4], d[3], exp_model});
    end

    // R4: sweep every value of the layer port
    for (int v = 0; v < 256; v++) begin
      wr(BASE + 8'd1, 8'(v), 1'b1);
      chk("R4 layer fields", {27'd0, gram_bank, vram_en, gram_en, blend_xor},
          32'(v % 32));
    end

    // R6: sweep every value of the page port
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      wr(BASE + 8'd5, d, 1'b1);
      chk("R6 mapping", {30'd0, map_cgrom, map_gram}, {30'd0, d[7], d[0]});
    end

    // R7: status read path
    @(negedge clk);
    status_in = 8'h5C; io_addr = BASE + 8'd5; io_rd = 1'b1;
    #1 chk("R7 status", 32'(io_rdata), 32'h5C);
    status_in = 8'hA3;
    #1 chk("R7 status follows", 32'(io_rdata), 32'hA3);
    io_addr = BASE;
    #1 chk("R7 other port", 32'(io_rdata), 0);
    io_addr = BASE + 8'd5; io_rd = 1'b0;
    #1 chk("R7 no read", 32'(io_rdata), 0);

    // R5: paint strobe for every bank and plane
    for (int b = 0; b < 4; b++) begin
      wr(BASE + 8'd1, 8'(b * 8), 1'b1);
      for (int p = 0; p < 3; p++) begin
        logic [7:0] m;
        m = 8'(b * 53 + p * 29 + 17);
        wr(BASE + 8'd2 + 8'(p), m, 1'b1);
        chk("R5 strobe high", 32'(gw_stb), 1);
        chk("R5 plane", 32'(gw_plane), 32'(p));
        chk("R5 mask", 32'(gw_mask), 32'(m));
        chk("R5 bank", 32'(gw_bank), 32'(b));
        @(negedge clk);
        chk("R5 strobe single", 32'(gw_stb), 0);
      end
    end

    // R8 R9: every enable, operator and pixel combination
    for (int g = 0; g < 8; g++) begin
      wr(BASE + 8'd1, 8'(g), 1'b1);
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 4; c++) begin
          logic [PIX_W-1:0] ve, ge, ex;
          ve = (g & 4) != 0 ? PIX_W'(a) : '0;
          ge = (g & 2) != 0 ? PIX_W'(c) : '0;
          ex = (g & 1) != 0 ? (ve ^ ge) : (ve | ge);
          vram_pix = PIX_W'(a);
          gram_pix = PIX_W'(c);
          @(negedge clk);
          chk((g & 6) == 0 ? "R9 disabled sources" : "R8 blend",
              32'(pix_out), 32'(ex));
        end
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule